// File: doc/BRIEF.md
# Power-Fail Reset Supervisor

This block turns two supply-status flags from external comparators into the control signals a memory subsystem and its processor need across a power failure. One flag says the supply is inside its full-function tolerance band. The other says the supply is above the level at which the backup energy source is switched in. Both flags are asynchronous to the clock and are resynchronised before use.

When the supply leaves tolerance, the block pulls the system reset line at once and turns on write protection. That write protection stands for the memory ignoring its inputs and floating its outputs. When the supply comes back, write protection lifts as soon as the tolerance flag is seen again. The reset line stays held for a fixed hold time, nominally 200 ms, which is counted in clock cycles from `CLK_HZ` and `HOLD_MS`. A new drop during the hold restarts that hold from zero. The backup select follows the switchover flag on its own.

Which tolerance variant is fitted (a 4.5 V or a 4.75 V full-function level) is set by the external comparator. The only place it shows here is the meaning of the in-tolerance flag.

Top module: `pfs_supervisor`

## Requirements
- R1: Each supply flag passes through two flip-flops: a change on an input first shows on the outputs after the second rising clock edge, and not after the first.
- R2: While the synchronised in-tolerance flag is low, `rst_pull_o` is 1. This output is the enable of an open-drain pad whose data is fixed low, so 1 means the reset line is pulled low and 0 means it is released.
- R3: After the synchronised in-tolerance flag rises, `rst_pull_o` stays 1 for exactly HOLD_CYCLES = (CLK_HZ/1000)*HOLD_MS further edges. Counted from the input change, it falls after edge 2+HOLD_CYCLES.
- R4: A drop of the in-tolerance flag before the hold completes restarts the hold from zero. If the drop reaches the timer in the same cycle the hold would complete, `rst_pull_o` shows no release pulse.
- R5: `wp_en_o` is 1 exactly while the synchronised in-tolerance flag is low. It does not wait for the reset hold.
- R6: `backup_sel_o` is 1 exactly while the synchronised switchover flag is low, independent of the tolerance flag.
- R7: After a synchronous reset (`rst_n` low at a clock edge), `rst_pull_o`=1, `wp_en_o`=1 and `backup_sel_o`=1.
- R8: A supply drop after the reset has been released pulls the reset again, and the next release waits a full new hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_in_tol_i | input | 1 | Asynchronous flag: supply above the full-function level |
| supply_above_sw_i | input | 1 | Asynchronous flag: supply above the backup switchover level |
| rst_pull_o | output | 1 | Open-drain reset pad enable, 1 = line pulled low |
| wp_en_o | output | 1 | Memory write protect, inputs ignored and outputs floated |
| backup_sel_o | output | 1 | 1 = backup energy source feeds the memory |

## Verification
Two events can land in the same cycle: the hold count completing and a new supply drop arriving at the timer. The bench provokes this by raising the in-tolerance flag and dropping it again exactly HOLD_CYCLES edges later. The synchronised drop then meets the final count edge, and the bench requires `rst_pull_o` to stay 1 through that cycle and the cycles after it. Write protect and backup switching also change together in that cycle, and a behavioural model compared on every clock judges all three outputs.

// File: rtl/pfs_pkg.sv
// Package: shared types and helpers for the power-fail supervisor.
// Assumes: the clock frequency is a whole multiple of 1 kHz for exact hold timing.
package pfs_pkg;

    // Bit positions of the supply flags in the synchroniser vector
    localparam int unsigned FLAG_TOL = 0;
    localparam int unsigned FLAG_SW  = 1;
    localparam int unsigned FLAG_N   = 2;

    // Converts a hold time in milliseconds to a count of clock cycles
    function automatic int unsigned hold_cycles(input int unsigned clk_hz,
                                                input int unsigned hold_ms);
        return (clk_hz / 1000) * hold_ms;
    endfunction

endpackage

// File: rtl/pfs_sync.sv
// Module: pfs_sync
// Brings WIDTH asynchronous level flags into the clock domain through two
// flip-flops per bit. It assumes the flags are quasi-static levels, so no
// pulse stretching or handshaking is needed.
module pfs_sync #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    // Two-stage capture per bit; reset reads as "supply bad"
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

    // R1
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q_o == $past(d_i, 2)));

endmodule

// File: rtl/pfs_hold_timer.sv
// Module: pfs_hold_timer
// Counts HOLD_CYCLES consecutive cycles with run_i high and then raises
// done_o. done_o stays high while run_i stays high. Any low cycle on run_i
// clears both the count and done_o. It assumes HOLD_CYCLES >= 1.
module pfs_hold_timer #(
    parameter int unsigned HOLD_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int unsigned CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Hold counter: restarts on any dropout, saturates through done_q
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o = done_q;

    // R4
    clear_on_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !done_o);

    // R3
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && run_i) |=> done_o);

    // R3
    done_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(run_i));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/pfs_supervisor.sv
// Module: pfs_supervisor
// Top of the power-fail supervisor. It synchronises the two supply flags,
// holds reset for a timed interval after recovery, and drives write protect
// and backup select straight from the synchronised flags. It assumes the
// flags come from comparators with their own hysteresis.
module pfs_supervisor #(
    parameter int unsigned CLK_HZ  = 1000000,
    parameter int unsigned HOLD_MS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_in_tol_i,
    input  logic supply_above_sw_i,
    output logic rst_pull_o,
    output logic wp_en_o,
    output logic backup_sel_o
);

    import pfs_pkg::*;

    localparam int unsigned HOLD_CYCLES = hold_cycles(CLK_HZ, HOLD_MS);

    logic [FLAG_N-1:0] raw_flags;
    logic [FLAG_N-1:0] sync_flags;
    logic              tol_s;
    logic              sw_s;
    logic              hold_done;

    // Pack the asynchronous flags for the synchroniser
    always_comb begin
        raw_flags           = '0;
        raw_flags[FLAG_TOL] = supply_in_tol_i;
        raw_flags[FLAG_SW]  = supply_above_sw_i;
    end

    pfs_sync #(
        .WIDTH (FLAG_N)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (sync_flags)
    );

    assign tol_s = sync_flags[FLAG_TOL];
    assign sw_s  = sync_flags[FLAG_SW];

    pfs_hold_timer #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) i_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tol_s),
        .done_o (hold_done)
    );

    // Output decode: reset pad enable, write protect, backup source select
    always_comb begin
        rst_pull_o   = !tol_s || !hold_done;
        wp_en_o      = !tol_s;
        backup_sel_o = !sw_s;
    end

    // R5
    release_implies_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pull_o |-> !wp_en_o);

    // R2
    drop_pulls_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wp_en_o) |-> rst_pull_o);

    // R3
    release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_o) |-> $past(!wp_en_o));

endmodule

// File: tb/test_pfs_supervisor.sv
`timescale 1ns/1ps
module test_pfs_supervisor;

    localparam int CLK_HZ  = 1000;
    localparam int HOLD_MS = 12;
    localparam int HOLD    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tol = 1'b0;
    logic sw = 1'b0;
    logic pull, wp, bk;

    int total = 0;
    int bad = 0;

    // reference model state
    int m_t1 = 0, m_t = 0, m_s1 = 0, m_s = 0, m_cnt = 0;

    always #2 clk = ~clk;

    pfs_supervisor #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) i_pfs_supervisor (
        .clk(clk), .rst_n(rst_n),
        .supply_in_tol_i(tol), .supply_above_sw_i(sw),
        .rst_pull_o(pull), .wp_en_o(wp), .backup_sel_o(bk)
    );

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural model: flags delayed two edges, hold counted in integers
    always @(posedge clk) begin
        if (!rst_n) begin
            m_t1 = 0; m_t = 0; m_s1 = 0; m_s = 0; m_cnt = 0;
        end else begin
            if (m_t == 0) m_cnt = 0;
            else if (m_cnt < HOLD) m_cnt = m_cnt + 1;
            m_t = m_t1; m_t1 = int'(tol);
            m_s = m_s1; m_s1 = int'(sw);
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(pull, (m_t == 0) || (m_cnt < HOLD), "R3 model rst_pull");
            check(wp, m_t == 0, "R5 model wp_en");
            check(bk, m_s == 0, "R6 model backup_sel");
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        // R7 reset state
        check(pull, 1'b1, "R7 pull");
        check(wp, 1'b1, "R7 wp");
        check(bk, 1'b1, "R7 backup");
        rst_n = 1'b1;
        step(2);
        // R6 switchover independent of tolerance
        sw = 1'b1;
        step(1); check(bk, 1'b1, "R1 backup after one edge");
        step(1); check(bk, 1'b0, "R6 backup deselected");
        check(wp, 1'b1, "R6 wp unaffected");
        // R3 power-up hold
        tol = 1'b1;
        step(1); check(wp, 1'b1, "R1 wp after one edge");
        step(1); check(wp, 1'b0, "R5 wp lifts without hold");
        check(pull, 1'b1, "R3 pull during hold");
        step(HOLD - 1); check(pull, 1'b1, "R3 pull at last hold cycle");
        step(1); check(pull, 1'b0, "R3 pull released");
        // R2 / R8 drop after release
        tol = 1'b0;
        step(1); check(pull, 1'b0, "R1 pull after one edge");
        step(1); check(pull, 1'b1, "R2 pull on drop");
        check(wp, 1'b1, "R2 wp on drop");
        // R4 restart during hold
        tol = 1'b1; step(2 + HOLD / 2);
        tol = 1'b0; step(2); check(pull, 1'b1, "R4 pull on mid-hold drop");
        tol = 1'b1; step(1 + HOLD); check(pull, 1'b1, "R4 full hold restarted");
        step(1); check(pull, 1'b0, "R4 released after restarted hold");
        // R8 new full hold after a later drop
        tol = 1'b0; step(3);
        tol = 1'b1; step(1 + HOLD); check(pull, 1'b1, "R8 full new hold");
        step(1); check(pull, 1'b0, "R8 released");
        // R4 collision: drop reaches timer on the completing edge
        tol = 1'b0; step(4);
        tol = 1'b1; sw = 1'b1; step(HOLD);
        tol = 1'b0; sw = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step(1); check(pull, 1'b1, "R4 no release pulse on collision");
        end
        check(bk, 1'b1, "R6 backup on collision");
        // glitches and random levels, judged by the model
        tol = 1'b1; sw = 1'b1; step(HOLD + 4);
        tol = 1'b0; step(1); tol = 1'b1; step(2);
        check(pull, 1'b1, "R4 one-cycle glitch restarts hold");
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 24) == 0) tol = ~tol;
            if ($urandom_range(0, 30) == 0) sw = ~sw;
            step(1);
        end
        // R7 reset mid-run
        rst_n = 1'b0; step(1);
        check(pull, 1'b1, "R7 pull after reset");
        check(wp, 1'b1, "R7 wp after reset");
        check(bk, 1'b1, "R7 backup after reset");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule